// File: doc/BRIEF.md
# Single-Channel DMA Engine with Selectable Bus Acquisition

The block moves a run of 32-bit words between a fixed device data port and consecutive memory locations, so the processor does not have to copy each word. Software loads a memory byte address, a device port address, a byte count and a control word through a small word-addressed register port. Setting the start bit launches the transfer. After that the engine runs without help until the count is exhausted. It then flags completion in its status register and, if enabled, holds an interrupt line high until software acknowledges it.

Each word is handled as a read from the source side followed by a write to the destination side. Both sides are simple synchronous valid/ready ports. Before it touches either port, the engine requests a shared bus from an external arbiter. Software picks one of three policies for holding that bus. Cycle stealing gives the bus back after every word. Burst keeps the bus from the first word to the last. Transparent keeps the request raised but only moves data on cycles where the processor is not using memory.

Top module: `dma_ctrl`

## Requirements
- R1: Registers sit at word offsets 0 (memory byte address), 1 (device port address), 2 (byte count, bits 1:0 read as 0), 3 (control: bit 0 start, bit 1 direction, bits 3:2 mode, bit 4 interrupt enable) and 4 (status: bit 0 busy, bit 1 done). The start bit reads back as 0, and every register resets to 0.
- R2: With direction 0, each word is read from the device port and then written to memory. Memory receives the device words in the order the device supplied them, and the device address presented equals the programmed value.
- R3: With direction 1, each word is read from memory and then written to the device port. The device receives the memory words in ascending address order.
- R4: After each word the memory address grows by 4 and the count shrinks by 4. At completion the registers read back as start address + 4·n and 0.
- R5: At completion, busy reads 0 and done reads 1. The interrupt output equals done AND the interrupt-enable bit. It never rises while busy.
- R6: Writing status with bit 1 set clears done, which also drops the interrupt.
- R7: A start with a byte count of 0 sets done on the next edge without ever setting busy or requesting the bus.
- R8: Mode 00 (cycle steal) lowers the bus request for one cycle after every word. With grant and ready always high, busy lasts 3n−1 cycles and the request falls n times.
- R9: Mode 01 (burst) keeps the bus request high from start to finish. With grant and ready always high, busy lasts 2n cycles and the request falls exactly once.
- R10: Mode 10 (transparent) never drives a valid on either port in a cycle where the CPU-activity input is high.
- R11: No port valid is driven unless bus request and bus grant are both high.
- R12: While busy, writes to registers 0 to 3 have no effect. This includes a second start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register word offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational on reg_addr_i) |
| irq_o | output | 1 | Completion interrupt (level) |
| bus_req_o | output | 1 | Bus request to arbiter |
| bus_grant_i | input | 1 | Bus grant from arbiter |
| cpu_mem_active_i | input | 1 | CPU is accessing memory this cycle |
| mem_valid_o | output | 1 | Memory access valid |
| mem_we_o | output | 1 | Memory write (1) or read (0) |
| mem_addr_o | output | AW | Memory byte address |
| mem_wdata_o | output | DW | Memory write data |
| mem_ready_i | input | 1 | Memory accepts access |
| mem_rdata_i | input | DW | Memory read data |
| dev_valid_o | output | 1 | Device access valid |
| dev_we_o | output | 1 | Device write (1) or read (0) |
| dev_addr_o | output | AW | Device port address |
| dev_wdata_o | output | DW | Device write data |
| dev_ready_i | input | 1 | Device accepts access |
| dev_rdata_i | input | DW | Device read data |

## Verification
The situation that is hardest to reach from the ports is a transparent-mode transfer in which grant, processor activity and both ready signals all change from cycle to cycle. Only then can a data step that slips past an active processor cycle actually show up. The bench drives these four inputs from seeded random percentages at every falling edge. A monitor flags any port valid that coincides with processor activity or a missing grant. A second hard case is a register write that lands mid-transfer. The bench issues a full set of configuration writes and a second start right after launching a six-word burst, then confirms from the final readback that none of them took effect.

// File: rtl/dma_pkg.sv
package dma_pkg;
  typedef enum logic [1:0] {
    MODE_STEAL  = 2'b00,
    MODE_BURST  = 2'b01,
    MODE_TRANSP = 2'b10,
    MODE_RSVD   = 2'b11
  } mode_e;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_RD   = 2'd1,
    S_WR   = 2'd2,
    S_REL  = 2'd3
  } xfer_st_e;

  localparam logic [2:0] REG_MADDR = 3'd0;
  localparam logic [2:0] REG_DADDR = 3'd1;
  localparam logic [2:0] REG_COUNT = 3'd2;
  localparam logic [2:0] REG_CTRL  = 3'd3;
  localparam logic [2:0] REG_STAT  = 3'd4;
endpackage

// File: rtl/dma_regs.sv
module dma_regs
  import dma_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_we_i,
  input  logic [2:0]    reg_addr_i,
  input  logic [31:0]   reg_wdata_i,
  output logic [31:0]   reg_rdata_o,
  input  logic          word_done_i,
  input  logic          xfer_end_i,
  output logic [AW-1:0] maddr_o,
  output logic [AW-1:0] daddr_o,
  output logic          dir_o,
  output mode_e         mode_o,
  output logic          start_o,
  output logic          last_o,
  output logic          irq_o
);
  localparam int WW = CW - 2;

  logic [AW-1:0] maddr_q, daddr_q;
  logic [WW-1:0] cnt_q;
  logic          dir_q, ie_q, busy_q, done_q;
  mode_e         mode_q;

  logic cfg_wr, start_req, zero_start, clr_done;
  assign cfg_wr     = reg_we_i & ~busy_q;
  assign start_req  = cfg_wr && (reg_addr_i == REG_CTRL) && reg_wdata_i[0];
  assign start_o    = start_req && (cnt_q != '0);
  assign zero_start = start_req && (cnt_q == '0);
  assign clr_done   = reg_we_i && (reg_addr_i == REG_STAT) && reg_wdata_i[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      maddr_q <= '0;
      daddr_q <= '0;
      cnt_q   <= '0;
      dir_q   <= 1'b0;
      ie_q    <= 1'b0;
      mode_q  <= MODE_STEAL;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      if (cfg_wr && reg_addr_i == REG_MADDR) maddr_q <= reg_wdata_i[AW-1:0];
      else if (word_done_i)                  maddr_q <= maddr_q + AW'(4);

      if (cfg_wr && reg_addr_i == REG_DADDR) daddr_q <= reg_wdata_i[AW-1:0];

      if (cfg_wr && reg_addr_i == REG_COUNT) cnt_q <= reg_wdata_i[CW-1:2];
      else if (word_done_i)                  cnt_q <= cnt_q - WW'(1);

      if (cfg_wr && reg_addr_i == REG_CTRL) begin
        dir_q  <= reg_wdata_i[1];
        mode_q <= mode_e'(reg_wdata_i[3:2]);
        ie_q   <= reg_wdata_i[4];
      end

      if (start_o)         busy_q <= 1'b1;
      else if (xfer_end_i) busy_q <= 1'b0;

      if (xfer_end_i || zero_start) done_q <= 1'b1;
      else if (clr_done)            done_q <= 1'b0;
    end
  end

  always_comb begin
    unique case (reg_addr_i)
      REG_MADDR: reg_rdata_o = 32'(maddr_q);
      REG_DADDR: reg_rdata_o = 32'(daddr_q);
      REG_COUNT: reg_rdata_o = 32'({cnt_q, 2'b00});
      REG_CTRL:  reg_rdata_o = {27'd0, ie_q, mode_q, dir_q, 1'b0};
      REG_STAT:  reg_rdata_o = {30'd0, done_q, busy_q};
      default:   reg_rdata_o = '0;
    endcase
  end

  assign maddr_o = maddr_q;
  assign daddr_o = daddr_q;
  assign dir_o   = dir_q;
  assign mode_o  = mode_q;
  assign last_o  = (cnt_q == WW'(1));
  assign irq_o   = done_q & ie_q;

  p_step_busy_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_done_i |-> (busy_q && cnt_q != '0));

  p_cfg_frozen_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |=> ($stable(daddr_q) && $stable(mode_q) && $stable(dir_q) && $stable(ie_q)));

  p_zero_start_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    zero_start |=> (!busy_q && done_q));
endmodule

// File: rtl/dma_bus_gate.sv
module dma_bus_gate
  import dma_pkg::*;
(
  input  logic  want_i,
  input  mode_e mode_i,
  input  logic  bus_grant_i,
  input  logic  cpu_mem_active_i,
  output logic  bus_req_o,
  output logic  go_o
);
  logic cpu_clear;
  // transparent mode only moves data on cycles the CPU leaves idle
  assign cpu_clear = (mode_i != MODE_TRANSP) || !cpu_mem_active_i;
  assign bus_req_o = want_i;
  assign go_o      = want_i && bus_grant_i && cpu_clear;
endmodule

// File: rtl/dma_engine.sv
module dma_engine
  import dma_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          last_i,
  input  logic          dir_i,
  input  mode_e         mode_i,
  input  logic          go_i,
  input  logic [AW-1:0] maddr_i,
  input  logic [AW-1:0] daddr_i,
  output logic          want_o,
  output logic          word_done_o,
  output logic          xfer_end_o,
  output logic          mem_valid_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic          mem_ready_i,
  input  logic [DW-1:0] mem_rdata_i,
  output logic          dev_valid_o,
  output logic          dev_we_o,
  output logic [AW-1:0] dev_addr_o,
  output logic [DW-1:0] dev_wdata_o,
  input  logic          dev_ready_i,
  input  logic [DW-1:0] dev_rdata_i
);
  xfer_st_e      st_q;
  logic [DW-1:0] data_q;
  logic          src_ready, dst_ready, rd_hs;
  logic [DW-1:0] src_data;

  // dir 1: memory is the source
  assign src_ready = dir_i ? mem_ready_i : dev_ready_i;
  assign dst_ready = dir_i ? dev_ready_i : mem_ready_i;
  assign src_data  = dir_i ? mem_rdata_i : dev_rdata_i;

  assign want_o      = (st_q == S_RD) || (st_q == S_WR);
  assign rd_hs       = (st_q == S_RD) && go_i && src_ready;
  assign word_done_o = (st_q == S_WR) && go_i && dst_ready;
  assign xfer_end_o  = word_done_o && last_i;

  always_comb begin
    mem_valid_o = 1'b0;
    mem_we_o    = 1'b0;
    dev_valid_o = 1'b0;
    dev_we_o    = 1'b0;
    if (st_q == S_RD) begin
      if (dir_i) mem_valid_o = go_i;
      else       dev_valid_o = go_i;
    end else if (st_q == S_WR) begin
      if (dir_i) begin dev_valid_o = go_i; dev_we_o = 1'b1; end
      else       begin mem_valid_o = go_i; mem_we_o = 1'b1; end
    end
  end

  assign mem_addr_o  = maddr_i;
  assign dev_addr_o  = daddr_i;
  assign mem_wdata_o = data_q;
  assign dev_wdata_o = data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= S_IDLE;
      data_q <= '0;
    end else begin
      if (rd_hs) data_q <= src_data;
      unique case (st_q)
        S_IDLE: if (start_i) st_q <= S_RD;
        S_RD:   if (rd_hs)   st_q <= S_WR;
        S_WR: begin
          if (word_done_o) begin
            if (last_i)                                           st_q <= S_IDLE;
            else if (mode_i == MODE_BURST || mode_i == MODE_TRANSP) st_q <= S_RD;
            else                                                  st_q <= S_REL;
          end
        end
        S_REL:  st_q <= S_RD;
        default: st_q <= S_IDLE;
      endcase
    end
  end

  p_one_side_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_valid_o && dev_valid_o));

  p_steal_gap_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_STEAL && word_done_o && !last_i) |=> !want_o);

  p_burst_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_BURST && want_o && !xfer_end_o) |=> want_o);
endmodule

// File: rtl/dma_ctrl.sv
module dma_ctrl
  import dma_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_we_i,
  input  logic [2:0]    reg_addr_i,
  input  logic [31:0]   reg_wdata_i,
  output logic [31:0]   reg_rdata_o,
  output logic          irq_o,
  output logic          bus_req_o,
  input  logic          bus_grant_i,
  input  logic          cpu_mem_active_i,
  output logic          mem_valid_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic          mem_ready_i,
  input  logic [DW-1:0] mem_rdata_i,
  output logic          dev_valid_o,
  output logic          dev_we_o,
  output logic [AW-1:0] dev_addr_o,
  output logic [DW-1:0] dev_wdata_o,
  input  logic          dev_ready_i,
  input  logic [DW-1:0] dev_rdata_i
);
  logic [AW-1:0] maddr, daddr;
  logic          dir, start, last, go, want, word_done, xfer_end;
  mode_e         mode;

  dma_regs #(.AW(AW), .CW(CW)) u_regs (
    .clk_i, .rst_ni, .reg_we_i, .reg_addr_i, .reg_wdata_i, .reg_rdata_o,
    .word_done_i(word_done), .xfer_end_i(xfer_end),
    .maddr_o(maddr), .daddr_o(daddr), .dir_o(dir), .mode_o(mode),
    .start_o(start), .last_o(last), .irq_o
  );

  dma_bus_gate u_gate (
    .want_i(want), .mode_i(mode), .bus_grant_i, .cpu_mem_active_i,
    .bus_req_o, .go_o(go)
  );

  dma_engine #(.AW(AW), .DW(DW)) u_eng (
    .clk_i, .rst_ni, .start_i(start), .last_i(last), .dir_i(dir), .mode_i(mode),
    .go_i(go), .maddr_i(maddr), .daddr_i(daddr), .want_o(want),
    .word_done_o(word_done), .xfer_end_o(xfer_end),
    .mem_valid_o, .mem_we_o, .mem_addr_o, .mem_wdata_o, .mem_ready_i, .mem_rdata_i,
    .dev_valid_o, .dev_we_o, .dev_addr_o, .dev_wdata_o, .dev_ready_i, .dev_rdata_i
  );

  p_grant_needed_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_valid_o || dev_valid_o) |-> (bus_req_o && bus_grant_i));

  p_transp_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == MODE_TRANSP && (mem_valid_o || dev_valid_o)) |-> !cpu_mem_active_i);
endmodule

// File: tb/dma_ctrl_test.sv
module dma_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq, bus_req, bus_grant;
  logic        gnt_en = 1'b1, cpu_act = 1'b0, mem_rdy = 1'b1, dev_rdy = 1'b1;
  logic        mem_valid, mem_we, dev_valid, dev_we;
  logic [31:0] mem_addr, mem_wdata, mem_rdata, dev_addr, dev_wdata, dev_rdata;

  int nchk = 0, nerr = 0;
  int gnt_pct = 100, cpu_pct = 0, rdy_pct = 100;
  logic [31:0] mem [0:63];
  logic [31:0] dev_log [0:1023];
  int dev_wn = 0, dev_k = 0;
  int v_grant = 0, v_cpu = 0, v_daddr = 0, req_falls = 0, req_seen = 0;
  logic [31:0] exp_daddr = '0;
  logic req_prev = 1'b0;

  always #10 clk = ~clk;

  assign bus_grant = bus_req & gnt_en;
  assign mem_rdata = mem[mem_addr[7:2]];
  assign dev_rdata = pat(dev_k);

  dma_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .irq_o(irq),
    .bus_req_o(bus_req), .bus_grant_i(bus_grant), .cpu_mem_active_i(cpu_act),
    .mem_valid_o(mem_valid), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_ready_i(mem_rdy), .mem_rdata_i(mem_rdata),
    .dev_valid_o(dev_valid), .dev_we_o(dev_we), .dev_addr_o(dev_addr),
    .dev_wdata_o(dev_wdata), .dev_ready_i(dev_rdy), .dev_rdata_i(dev_rdata)
  );

  function automatic logic [31:0] pat(input int k);
    return (32'(k) * 32'h9E3779B1) ^ 32'h5A5A0F0F;
  endfunction

  // memory and device models
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 64; i++) mem[i] <= pat(i + 777);
    end else begin
      if (mem_valid && mem_rdy && mem_we) mem[mem_addr[7:2]] <= mem_wdata;
      if (dev_valid && dev_rdy) begin
        if (dev_we) begin dev_log[dev_wn] <= dev_wdata; dev_wn <= dev_wn + 1; end
        else dev_k <= dev_k + 1;
      end
    end
  end

  // random environment, driven away from the active edge
  always @(negedge clk) begin
    gnt_en  <= ($urandom % 100) < 32'(gnt_pct);
    cpu_act <= ($urandom % 100) < 32'(cpu_pct);
    mem_rdy <= ($urandom % 100) < 32'(rdy_pct);
    dev_rdy <= ($urandom % 100) < 32'(rdy_pct);
  end

  // port monitors
  always @(negedge clk) begin
    if (rst_n) begin
      if ((mem_valid || dev_valid) && !(bus_req && bus_grant)) v_grant++;
      if ((mem_valid || dev_valid) && cpu_act && uut.mode == dma_pkg::MODE_TRANSP) v_cpu++;
      if (dev_valid && dev_addr !== exp_daddr) v_daddr++;
      if (req_prev && !bus_req) req_falls++;
      if (bus_req) req_seen++;
      req_prev = bus_req;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  int busy_cyc, falls, seen;

  task automatic run_xfer(input int base, input logic [31:0] da, input int n,
                          input logic dir, input logic [1:0] mode, input logic ie,
                          input logic poke);
    int k0, wn0, vg0, vc0, vd0, f0, s0;
    logic [31:0] s, r;
    logic early;
    wr(3'd4, 32'h2);
    k0 = dev_k; wn0 = dev_wn; vg0 = v_grant; vc0 = v_cpu; vd0 = v_daddr;
    exp_daddr = da;
    wr(3'd0, 32'(base * 4));
    wr(3'd1, da);
    wr(3'd2, 32'(n * 4));
    f0 = req_falls; s0 = req_seen;
    wr(3'd3, {27'd0, ie, mode, dir, 1'b1});
    if (poke) begin // R12: all ignored while busy
      wr(3'd0, 32'hFFF0);
      wr(3'd1, 32'hDEAD0000);
      wr(3'd2, 32'h40);
      wr(3'd3, {27'd0, ~ie, ~mode, ~dir, 1'b1});
    end
    reg_addr = 3'd4;
    busy_cyc = 0; early = 1'b0;
    do begin
      #1 s = reg_rdata;
      if (s[0]) begin busy_cyc++; if (irq) early = 1'b1; end
      if (!s[1]) @(negedge clk);
    end while (!s[1]);
    repeat (2) @(negedge clk);
    falls = req_falls - f0; seen = req_seen - s0;
    for (int i = 0; i < n; i++) begin
      if (dir) chk("R3 device got memory word", dev_log[wn0 + i], mem[base + i]);
      else     chk("R2 memory got device word", mem[base + i], pat(k0 + i));
    end
    if (dir) chk("R3 device write count", 32'(dev_wn - wn0), 32'(n));
    chk("R2 device address seen", 32'(v_daddr - vd0), 0);
    chk("R11 access without grant", 32'(v_grant - vg0), 0);
    chk("R10 access while cpu active", 32'(v_cpu - vc0), 0);
    chk("R5 irq while busy", 32'(early), 0);
    rd(3'd0, r); chk("R4 final address", r, 32'(base * 4 + 4 * n));
    rd(3'd2, r); chk("R4 final count", r, 0);
    rd(3'd1, r); chk("R12 device address kept", r, da);
    rd(3'd3, r); chk("R12 control kept", r, {27'd0, ie, mode, dir, 1'b0});
    rd(3'd4, r); chk("R5 status done", r, 32'h2);
    chk("R5 irq level", 32'(irq), 32'(ie));
    wr(3'd4, 32'h2);
    rd(3'd4, r); chk("R6 done cleared", r, 0);
    chk("R6 irq dropped", 32'(irq), 0);
  endtask

  initial begin
    logic [31:0] r;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), r); chk("R1 reset value", r, 0);
    end
    chk("R1 reset irq", 32'(irq), 0);
    chk("R1 reset bus_req", 32'(bus_req), 0);
    // R1 readback
    wr(3'd0, 32'h0000_0100); wr(3'd1, 32'hA000_0040); wr(3'd2, 32'h0000_0023);
    wr(3'd3, 32'h0000_0016);
    rd(3'd0, r); chk("R1 maddr readback", r, 32'h100);
    rd(3'd1, r); chk("R1 daddr readback", r, 32'hA000_0040);
    rd(3'd2, r); chk("R1 count low bits zero", r, 32'h20);
    rd(3'd3, r); chk("R1 ctrl readback", r, 32'h16);
    rd(3'd4, r); chk("R1 status idle", r, 0);
    wr(3'd2, 0);
    // R9 burst, full grant
    run_xfer(4, 32'hA000_0010, 4, 1'b0, 2'b01, 1'b1, 1'b0);
    chk("R9 burst busy cycles", 32'(busy_cyc), 8);
    chk("R9 burst request falls", 32'(falls), 1);
    // R8 cycle steal, full grant
    run_xfer(10, 32'hA000_0020, 3, 1'b1, 2'b00, 1'b1, 1'b0);
    chk("R8 steal busy cycles", 32'(busy_cyc), 8);
    chk("R8 steal request falls", 32'(falls), 3);
    // R7 zero count
    run_xfer(20, 32'hA000_0030, 0, 1'b0, 2'b01, 1'b1, 1'b0);
    chk("R7 zero count no busy", 32'(busy_cyc), 0);
    chk("R7 zero count no request", 32'(seen), 0);
    // R5 interrupt disabled
    run_xfer(30, 32'hA000_0040, 2, 1'b1, 2'b01, 1'b0, 1'b0);
    // R12 config writes during a slow burst
    gnt_pct = 30;
    run_xfer(40, 32'hA000_0050, 6, 1'b0, 2'b01, 1'b1, 1'b1);
    // R10 transparent under heavy CPU activity
    gnt_pct = 100; cpu_pct = 60; rdy_pct = 70;
    run_xfer(12, 32'hA000_0060, 5, 1'b0, 2'b10, 1'b1, 1'b0);
    chk("R10 transparent request held", 32'(falls), 1);
    run_xfer(50, 32'hA000_0070, 5, 1'b1, 2'b10, 1'b1, 1'b0);
    // random mix
    for (int t = 0; t < 10; t++) begin
      int n;
      n = 1 + int'($urandom % 8);
      gnt_pct = 40 + int'($urandom % 61);
      cpu_pct = int'($urandom % 70);
      rdy_pct = 50 + int'($urandom % 51);
      run_xfer(int'($urandom % 32'(64 - n)), $urandom & 32'hFFFF_FFFC, n,
               1'($urandom), 2'($urandom % 3), 1'($urandom), 1'b0);
    end
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule